// File: doc/BRIEF.md
# Indexed CRT Timing Controller

This block produces the raster timing for a character-based CRT display. Each clock cycle is one character clock. A horizontal counter steps across each scanline. A scanline counter steps through the lines of a character row, and a row counter steps through the rows of a frame. Optional extra scanlines can follow the last row before the frame restarts. From these counters the block derives a display-enable window, horizontal and vertical sync pulses, and a linear video-memory address. The address begins each frame at a programmable origin.

Software programs the block through two ports. A write to the index port chooses one of sixteen 8-bit registers, and a write to the value port stores a byte into the chosen register. The value-read port always returns the chosen register one cycle later. A separate status byte shows the live sync levels and a fixed card identification code. Moving the origin register pair scrolls or pans the picture. The new origin takes effect at the next frame boundary.

Top module: `crtc_timing_ctrl`

## Requirements
- R1: A write with `idx_we` stores `host_wdata` as the selected index. A write with `val_we` stores `host_wdata` into the register chosen by the index held before that edge. `val_rdata` shows the selected register on the cycle after the selection or the write.
- R2: Every register 0x00 to 0x0F reads back exactly the 8-bit value last written to it, including the patterns 0x66 and 0x99 on register 0x0F.
- R3: An index of 0x10 or higher selects nothing. A value write is dropped and leaves every register unchanged, and `val_rdata` reads 0.
- R4: Register 0x08 accepts the value 2 and reads it back, and writing it leaves the timing unchanged.
- R5: `h_pos` counts 0 up to the value in register 0x00, then returns to 0. Each pass is one scanline.
- R6: `v_line` counts 0 up to register 0x09 within a row. Then `v_row` advances, from 0 up to register 0x04. After that row, `v_line` counts 0 up to register 0x05 minus one while `v_row` holds. When register 0x05 is 0, the frame restarts straight after the last row.
- R7: `disp_en` is high exactly when `h_pos` is below register 0x01, `v_row` is below register 0x06, and the block is not in the extra scanlines.
- R8: `hsync` is high when `h_pos` lies in the range from register 0x02 up to, but not including, register 0x02 plus register 0x03, cut off at the end of the line. `vsync` is high on every scanline of the row equal to register 0x07, and never during the extra scanlines.
- R9: `mem_addr` equals the row base plus the smaller of `h_pos` and register 0x01. The row base grows by register 0x01 at each row end. The address wraps modulo 2^16.
- R10: The frame origin is {register 0x0C, register 0x0D}, with 0x0C as the high byte. It is loaded as the row base only at a frame restart, so a change made during a frame applies from the next frame.
- R11: `status_rdata` has bit 0 equal to `hsync`, bit 7 equal to `vsync`, bits 6:4 equal to the `CARD_ID` parameter, and bits 3:1 equal to zero.
- R12: With the monochrome graphics values (0x35, 0x2D, 0x2E, 0x07, 0x5B, 0x02, 0x57, 0x57, max scanline 0x03) a frame has 348 displayed scanlines. With the text values (0x61, 0x50, 0x52, 0x0F, 0x19, 0x06, 0x19, 0x19, max scanline 0x0D) a frame has 350.
- R13: While `rst` is high, every counter, address, sync, enable and read output is zero, and `status_rdata` shows only the card code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Write `host_wdata` to the index port |
| val_we | input | 1 | Write `host_wdata` to the selected register |
| host_wdata | input | 8 | Host write data |
| val_rdata | output | 8 | Selected register contents |
| status_rdata | output | 8 | Sync levels and card code |
| h_pos | output | 8 | Character position in the scanline |
| v_row | output | 8 | Character row in the frame |
| v_line | output | 8 | Scanline within row, or extra-line index |
| disp_en | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| mem_addr | output | 16 | Linear video memory address |

## Verification
The bench runs several programmings against a cycle-exact scoreboard computed in closed form. One run uses a nonzero extra-scanline count, a sync window that runs past the line end, and an origin change in mid-frame. A design that switched origin at once would corrupt the rest of that frame, and one that dropped the extra lines would end the frame early. A second run uses a zero extra-line count and an origin near 0xFFFF, which catches a missing empty-adjust path and an address that saturates instead of wrapping. Register tests cover out-of-range indexes, so a design that aliased index 0x10 onto register 0x00 would corrupt the horizontal total. Full graphics and text frames confirm the displayed line counts.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int DW   = 8;
  localparam int AW   = 16;
  localparam int NREG = 16;
  localparam int RIW  = $clog2(NREG);

  // register numbers decoded by the timing logic
  localparam int RG_HTOT  = 0;
  localparam int RG_HDISP = 1;
  localparam int RG_HSPOS = 2;
  localparam int RG_HSWID = 3;
  localparam int RG_VTOT  = 4;
  localparam int RG_VADJ  = 5;
  localparam int RG_VDISP = 6;
  localparam int RG_VSPOS = 7;
  localparam int RG_MAXSL = 9;
  localparam int RG_ORGH  = 12;
  localparam int RG_ORGL  = 13;

  typedef struct packed {
    logic [DW-1:0] htot;
    logic [DW-1:0] hdisp;
    logic [DW-1:0] hspos;
    logic [DW-1:0] hswid;
    logic [DW-1:0] vtot;
    logic [DW-1:0] vadj;
    logic [DW-1:0] vdisp;
    logic [DW-1:0] vspos;
    logic [DW-1:0] maxsl;
    logic [AW-1:0] origin;
  } crt_cfg_t;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_we,
  input  logic          val_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] sel,
  output crt_cfg_t      cfg
);
  logic [DW-1:0] sel_q;
  logic [DW-1:0] regs_q [NREG];
  logic          sel_ok;

  assign sel_ok = (sel_q < DW'(NREG));
  assign sel    = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      rdata <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      if (idx_we) sel_q <= wdata;
      if (val_we && sel_ok) regs_q[sel_q[RIW-1:0]] <= wdata;
      rdata <= sel_ok ? regs_q[sel_q[RIW-1:0]] : '0;
    end
  end

  always_comb begin
    cfg.htot   = regs_q[RG_HTOT];
    cfg.hdisp  = regs_q[RG_HDISP];
    cfg.hspos  = regs_q[RG_HSPOS];
    cfg.hswid  = regs_q[RG_HSWID];
    cfg.vtot   = regs_q[RG_VTOT];
    cfg.vadj   = regs_q[RG_VADJ];
    cfg.vdisp  = regs_q[RG_VDISP];
    cfg.vspos  = regs_q[RG_VSPOS];
    cfg.maxsl  = regs_q[RG_MAXSL];
    cfg.origin = {regs_q[RG_ORGH], regs_q[RG_ORGL]};
  end
endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount
  import crtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] htot,
  input  logic [DW-1:0] hdisp,
  input  logic [DW-1:0] hspos,
  input  logic [DW-1:0] hswid,
  output logic [DW-1:0] h_pos,
  output logic          hde,
  output logic          hsync,
  output logic          line_end
);
  logic [DW-1:0] h_nxt;

  always_comb begin
    line_end = (h_pos >= htot);
    h_nxt    = line_end ? '0 : h_pos + DW'(1);
  end

  // strobes are computed from the next count so they line up with h_pos
  always_ff @(posedge clk) begin
    if (rst) begin
      h_pos <= '0;
      hde   <= 1'b0;
      hsync <= 1'b0;
    end else begin
      h_pos <= h_nxt;
      hde   <= (h_nxt < hdisp);
      hsync <= (h_nxt >= hspos) && ((h_nxt - hspos) < hswid);
    end
  end
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount
  import crtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [DW-1:0] vtot,
  input  logic [DW-1:0] vadj,
  input  logic [DW-1:0] vdisp,
  input  logic [DW-1:0] vspos,
  input  logic [DW-1:0] maxsl,
  output logic [DW-1:0] v_row,
  output logic [DW-1:0] v_line,
  output logic          vde,
  output logic          vsync,
  output logic          row_end,
  output logic          frame_end
);
  logic          in_adj, adj_n;
  logic [DW-1:0] row_n, line_n;
  logic          row_wrap, last_row, adj_done, frame_wrap;

  always_comb begin
    row_wrap   = !in_adj && (v_line >= maxsl);
    last_row   = (v_row >= vtot);
    adj_done   = in_adj && (((DW+1)'(v_line) + (DW+1)'(1)) >= (DW+1)'(vadj));
    frame_wrap = adj_done || (row_wrap && last_row && (vadj == '0));
    row_end    = line_end && row_wrap;
    frame_end  = line_end && frame_wrap;
    row_n  = v_row;
    line_n = v_line;
    adj_n  = in_adj;
    if (line_end) begin
      if (frame_wrap) begin
        row_n  = '0;
        line_n = '0;
        adj_n  = 1'b0;
      end else if (row_wrap && last_row) begin
        line_n = '0;
        adj_n  = 1'b1;
      end else if (row_wrap) begin
        row_n  = v_row + DW'(1);
        line_n = '0;
      end else begin
        line_n = v_line + DW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_row  <= '0;
      v_line <= '0;
      in_adj <= 1'b0;
      vde    <= 1'b0;
      vsync  <= 1'b0;
    end else begin
      v_row  <= row_n;
      v_line <= line_n;
      in_adj <= adj_n;
      vde    <= !adj_n && (row_n < vdisp);
      vsync  <= !adj_n && (row_n == vspos);
    end
  end
endmodule

// File: rtl/crtc_addr.sv
module crtc_addr
  import crtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic          row_end,
  input  logic          frame_end,
  input  logic [DW-1:0] h_pos,
  input  logic [DW-1:0] hdisp,
  input  logic [AW-1:0] origin,
  output logic [AW-1:0] ma
);
  logic [AW-1:0] row_base, next_base;

  assign next_base = row_base + AW'(hdisp);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_base <= '0;
      ma       <= '0;
    end else if (line_end) begin
      if (frame_end) begin
        row_base <= origin;
        ma       <= origin;
      end else if (row_end) begin
        row_base <= next_base;
        ma       <= next_base;
      end else begin
        ma       <= row_base;
      end
    end else if (h_pos < hdisp) begin
      ma <= ma + AW'(1);
    end
  end
endmodule

// File: rtl/crtc_timing_ctrl.sv
module crtc_timing_ctrl
  import crtc_pkg::*;
#(
  parameter logic [2:0] CARD_ID = 3'b101
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_we,
  input  logic          val_we,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    val_rdata,
  output logic [7:0]    status_rdata,
  output logic [7:0]    h_pos,
  output logic [7:0]    v_row,
  output logic [7:0]    v_line,
  output logic          disp_en,
  output logic          hsync,
  output logic          vsync,
  output logic [15:0]   mem_addr
);
  crt_cfg_t      cfg;
  logic [DW-1:0] sel_idx;
  logic          hde, vde, line_end, row_end, frame_end;

  crtc_regs regs_i (
    .clk(clk), .rst(rst), .idx_we(idx_we), .val_we(val_we),
    .wdata(host_wdata), .rdata(val_rdata), .sel(sel_idx), .cfg(cfg)
  );

  crtc_hcount hcnt_i (
    .clk(clk), .rst(rst), .htot(cfg.htot), .hdisp(cfg.hdisp),
    .hspos(cfg.hspos), .hswid(cfg.hswid), .h_pos(h_pos),
    .hde(hde), .hsync(hsync), .line_end(line_end)
  );

  crtc_vcount vcnt_i (
    .clk(clk), .rst(rst), .line_end(line_end), .vtot(cfg.vtot),
    .vadj(cfg.vadj), .vdisp(cfg.vdisp), .vspos(cfg.vspos),
    .maxsl(cfg.maxsl), .v_row(v_row), .v_line(v_line), .vde(vde),
    .vsync(vsync), .row_end(row_end), .frame_end(frame_end)
  );

  crtc_addr addr_i (
    .clk(clk), .rst(rst), .line_end(line_end), .row_end(row_end),
    .frame_end(frame_end), .h_pos(h_pos), .hdisp(cfg.hdisp),
    .origin(cfg.origin), .ma(mem_addr)
  );

  assign disp_en      = hde && vde;
  assign status_rdata = {vsync, CARD_ID, 3'b000, hsync};
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  h_pos,
  input logic [7:0]  htot,
  input logic [7:0]  hdisp,
  input logic [7:0]  hspos,
  input logic        disp_en,
  input logic        hsync,
  input logic [15:0] mem_addr,
  input logic [7:0]  sel_idx,
  input logic [7:0]  val_rdata
);
  // R5
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (h_pos >= htot) |=> (h_pos == 8'd0));

  // R5
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    (h_pos < htot) |=> (h_pos == $past(h_pos) + 8'd1));

  // R7
  de_window_chk: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> (h_pos < $past(hdisp)));

  // R8
  hs_start_chk: assert property (@(posedge clk) disable iff (rst)
    hsync |-> (h_pos >= $past(hspos)));

  // R9
  ma_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((h_pos < htot) && (h_pos < hdisp)) |=> (mem_addr == $past(mem_addr) + 16'd1));

  // R3
  oob_read_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_idx >= 8'd16) |=> (val_rdata == 8'd0));
endmodule

bind crtc_timing_ctrl crtc_timing_chk chk_i (
  .clk(clk), .rst(rst), .h_pos(h_pos), .htot(cfg.htot), .hdisp(cfg.hdisp),
  .hspos(cfg.hspos), .disp_en(disp_en), .hsync(hsync), .mem_addr(mem_addr),
  .sel_idx(sel_idx), .val_rdata(val_rdata)
);

// File: tb/crtc_timing_ctrl_tb_top.sv
module crtc_timing_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 190000;
  localparam logic [2:0] CARD = 3'b101;

  logic        clk = 1'b0;
  logic        rst;
  logic        idx_we, val_we;
  logic [7:0]  host_wdata;
  logic [7:0]  val_rdata, status_rdata, h_pos, v_row, v_line;
  logic        disp_en, hsync, vsync;
  logic [15:0] mem_addr;

  crtc_timing_ctrl #(.CARD_ID(CARD)) dut_i (
    .clk(clk), .rst(rst), .idx_we(idx_we), .val_we(val_we),
    .host_wdata(host_wdata), .val_rdata(val_rdata), .status_rdata(status_rdata),
    .h_pos(h_pos), .v_row(v_row), .v_line(v_line), .disp_en(disp_en),
    .hsync(hsync), .vsync(vsync), .mem_addr(mem_addr)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [7:0]  hp;
    logic [7:0]  row;
    logic [7:0]  ln;
    logic        de;
    logic        hs;
    logic        vs;
    logic [15:0] ma;
    logic [7:0]  st;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int de_lines = 0;
  int c_ht, c_hd, c_hp, c_hw, c_vt, c_va, c_vd, c_vp, c_ms;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // closed-form expectation for cycle t after a frame start
  function automatic exp_t model(input int t, input logic [15:0] st_a, input logic [15:0] st_b);
    exp_t m;
    int h, s, rl, f, l, hc, lf, fr, row, ln, ri;
    logic adj;
    logic [15:0] st;
    h  = c_ht + 1;
    s  = c_ms + 1;
    rl = (c_vt + 1) * s;
    f  = rl + c_va;
    l  = t / h;
    hc = t % h;
    fr = l / f;
    lf = l % f;
    st = (fr == 0) ? st_a : st_b;
    if (lf < rl) begin
      row = lf / s; ln = lf % s; adj = 1'b0; ri = row;
    end else begin
      row = c_vt; ln = lf - rl; adj = 1'b1; ri = c_vt + 1;
    end
    m.hp  = 8'(hc);
    m.row = 8'(row);
    m.ln  = 8'(ln);
    m.de  = (hc < c_hd) && !adj && (row < c_vd);
    m.hs  = (hc >= c_hp) && ((hc - c_hp) < c_hw);
    m.vs  = !adj && (row == c_vp);
    m.ma  = 16'(int'(st) + ri * c_hd + ((hc < c_hd) ? hc : c_hd));
    m.st  = {m.vs, CARD, 3'b000, m.hs};
    return m;
  endfunction

  // monitor: compare one expected item per cycle
  always begin
    exp_t e;
    @(posedge clk);
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check("R5 h_pos", 32'(h_pos), 32'(e.hp));
      check("R6 v_row", 32'(v_row), 32'(e.row));
      check("R6 v_line", 32'(v_line), 32'(e.ln));
      check("R7 disp_en", 32'(disp_en), 32'(e.de));
      check("R8 hsync", 32'(hsync), 32'(e.hs));
      check("R8 vsync", 32'(vsync), 32'(e.vs));
      check("R9/R10 mem_addr", 32'(mem_addr), 32'(e.ma));
      check("R11 status", 32'(status_rdata), 32'(e.st));
      if (disp_en && h_pos == 8'd0) de_lines++;
    end
  end

  task automatic wr_idx(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; host_wdata = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr_val(input logic [7:0] v);
    @(negedge clk); val_we = 1'b1; host_wdata = v;
    @(negedge clk); val_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    wr_idx(i);
    wr_val(v);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i);
    @(negedge clk);
    v = val_rdata;
  endtask

  task automatic prog(input int ht, hd, hp, hw, vt, va, vd, vp, ms, input logic [15:0] org);
    c_ht = ht; c_hd = hd; c_hp = hp; c_hw = hw;
    c_vt = vt; c_va = va; c_vd = vd; c_vp = vp; c_ms = ms;
    wr_reg(8'h00, 8'(ht)); wr_reg(8'h01, 8'(hd));
    wr_reg(8'h02, 8'(hp)); wr_reg(8'h03, 8'(hw));
    wr_reg(8'h04, 8'(vt)); wr_reg(8'h05, 8'(va));
    wr_reg(8'h06, 8'(vd)); wr_reg(8'h07, 8'(vp));
    wr_reg(8'h08, 8'h02);  wr_reg(8'h09, 8'(ms));
    wr_reg(8'h0C, org[15:8]); wr_reg(8'h0D, org[7:0]);
  endtask

  // driver: align on a frame start, push expectations, optionally move origin
  task automatic run_frames(input int n, input logic [15:0] st_a, input logic [15:0] st_b,
                            input int want_lines, input string tag);
    int prev;
    prev = 0;
    forever begin
      @(negedge clk);
      if (h_pos == 8'd0 && v_row == 8'd0 && v_line == 8'd0 && prev != 0) break;
      prev = int'(h_pos);
    end
    de_lines = 0;
    for (int t = 1; t <= n; t++) exp_q.push_back(model(t, st_a, st_b));
    if (st_b != st_a) begin
      wr_reg(8'h0C, st_b[15:8]);
      wr_reg(8'h0D, st_b[7:0]);
    end
    while (exp_q.size() != 0) @(negedge clk);
    if (want_lines >= 0) check(tag, 32'(de_lines), 32'(want_lines));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst = 1'b1; idx_we = 1'b0; val_we = 1'b0; host_wdata = 8'h00;
    repeat (3) @(negedge clk);
    // R13 reset state, sampled while reset is held
    check("R13 h_pos", 32'(h_pos), 0);
    check("R13 v_row", 32'(v_row), 0);
    check("R13 v_line", 32'(v_line), 0);
    check("R13 syncs", 32'({disp_en, hsync, vsync}), 0);
    check("R13 mem_addr", 32'(mem_addr), 0);
    check("R13 val_rdata", 32'(val_rdata), 0);
    check("R13 status", 32'(status_rdata), 32'h50);
    rst = 1'b0;

    // R1 R2: all registers read back what was written
    for (int i = 0; i < 16; i++) wr_reg(8'(i), 8'((i * 37) ^ 8'hA5));
    for (int i = 0; i < 16; i++) begin
      rd_reg(8'(i), rv);
      check("R1/R2 readback", 32'(rv), 32'(8'((i * 37) ^ 8'hA5)));
    end
    wr_reg(8'h0F, 8'h66); rd_reg(8'h0F, rv); check("R2 cursor low 66", 32'(rv), 32'h66);
    wr_reg(8'h0F, 8'h99); rd_reg(8'h0F, rv); check("R2 cursor low 99", 32'(rv), 32'h99);

    // R3: out-of-range index is ignored and reads zero
    wr_reg(8'h00, 8'h3C);
    wr_reg(8'h10, 8'hEE);
    @(negedge clk);
    check("R3 read of index 0x10", 32'(val_rdata), 0);
    wr_reg(8'hFF, 8'h77);
    rd_reg(8'h00, rv); check("R3 reg0 untouched", 32'(rv), 32'h3C);
    rd_reg(8'hFF, rv); check("R3 read of index 0xFF", 32'(rv), 0);

    // config A: extra scanlines, clipped hsync, origin moved mid-frame (R4 R6 R10)
    prog(9, 6, 8, 5, 4, 3, 3, 4, 2, 16'h1234);
    rd_reg(8'h08, rv); check("R4 interlace readback", 32'(rv), 32'h02);
    run_frames(2 * 180 + 15, 16'h1234, 16'h0300, -1, "R6");

    // config B: no extra scanlines, address wrap (R6 R9)
    prog(5, 4, 4, 1, 2, 0, 2, 1, 1, 16'hFFF8);
    run_frames(36 + 10, 16'hFFF8, 16'hFFF8, -1, "R9");

    // R12 graphics frame
    prog(8'h35, 8'h2D, 8'h2E, 8'h07, 8'h5B, 8'h02, 8'h57, 8'h57, 8'h03, 16'h0000);
    run_frames(54 * 370, 16'h0000, 16'h0000, 348, "R12 graphics displayed lines");

    // R12 text frame
    prog(8'h61, 8'h50, 8'h52, 8'h0F, 8'h19, 8'h06, 8'h19, 8'h19, 8'h0D, 16'h0000);
    run_frames(98 * 370, 16'h0000, 16'h0000, 350, "R12 text displayed lines");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule